// File: doc/BRIEF.md
# Inrush Overcurrent Profile Sequencer

This block produces the overcurrent threshold for one switched load channel. The limit changes over time after each switch-on. When the channel turns on, the threshold starts at a high inrush level. It then steps down through a staircase of timed segments and comes to rest at a steady-state level, which software chooses. This lets lamps and gas-discharge loads draw their large cold-start current, while the wiring is still protected once the load has settled. The load current arrives as a digitized code. The comparison against the active limit is filtered over several consecutive samples before an overcurrent trip is flagged.

The block tracks a warmth index to handle a load that is switched back on before it has cooled. While the channel is on, the index follows the profile segment that has been reached. While the channel is off, the index drops by one segment for every elapsed cooling unit. The next switch-on re-enters the profile at that segment, so a warm filament is not granted the full inrush allowance again. Configuration inputs control the shape of the profile:

- a discharge-lamp shape select;
- a high-inrush select;
- a scale for the inrush segment lengths;
- a cooling-rate select;
- a steady-state level select;
- a fixed mode that skips the profile entirely.

Top module: `ocp_inrush_seq`

## Requirements
- R1: After reset, thr_code is 0, oc_trip is 0, and the warmth index is 0, so the first switch-on starts at segment 0.
- R2: The cycle after on_cmd is first sampled high, the profile starts. While on_cmd is sampled low, thr_code reads 0 from the following cycle on.
- R3: Segments 0 to 5 last DUR0 to DUR5 clock cycles in turn, then prof_seg reads 6 (steady state). The lengths of segments 0 and 1 are multiplied by 2 to the power of inrush_sel.
- R4: With xen_shape=1 and hi_inrush=0, the thresholds for segments 0 to 5 are LVL_H1, LVL_H2, LVL_C1, LVL_C2, LVL_C3, LVL_C4.
- R5: In segment 6 the threshold is set by ss_sel: 00 gives LVL_LO2, 01 gives LVL_LO3, 10 gives LVL_LO4 and 11 gives LVL_LO1.
- R6: With xen_shape=0, segments 4 and 5 keep the LVL_C2 threshold.
- R7: With hi_inrush=1, segment 1 uses LVL_H1 instead of LVL_H2.
- R8: A switch-on restarts the profile at the last segment reached minus the number of whole cooling units spent off, with a floor of 0. One cooling unit is COOL_BASE shifted left by cool_sel, in clock cycles.
- R9: With fixed_mode=1, a switch-on goes straight to segment 6 and the steady-state threshold.
- R10: oc_trip rises the cycle after the TRIP_RUN-th consecutive sample_valid cycle in which, while the channel is on, cur_code is strictly greater than thr_code. A valid sample that is equal or lower clears the run. Cycles without sample_valid leave the run unchanged. Samples taken while the channel is off are ignored.
- R11: oc_trip stays high while on_cmd stays high. It clears the cycle after on_cmd is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| on_cmd | input | 1 | Channel on command |
| sample_valid | input | 1 | cur_code carries a new sample this cycle |
| cur_code | input | CUR_W | Digitized load current |
| xen_shape | input | 1 | 1: discharge-lamp profile shape (uses LVL_C3/LVL_C4) |
| hi_inrush | input | 1 | 1: hold the top inrush level through segment 1 |
| ss_sel | input | 2 | Steady-state level select |
| cool_sel | input | 2 | Cooling unit scale, shift of COOL_BASE |
| inrush_sel | input | 2 | Inrush segment length scale, shift of DUR0/DUR1 |
| fixed_mode | input | 1 | 1: no staircase, steady-state limit from switch-on |
| thr_code | output | CUR_W | Active overcurrent threshold, 0 while off |
| prof_seg | output | 3 | Current profile segment, 6 = steady state |
| oc_trip | output | 1 | Filtered overcurrent flag |

## Verification
A segment counter that advances one cycle early or late shows up as the wrong thr_code and prof_seg value at a segment boundary. The bench compares these two outputs on every cycle of each on period, so such an error is caught in the same cycle. A warmth index with a wrong value stays hidden until the next switch-on. From that cycle on, the profile restarts at the wrong segment, and the first checked cycle after switch-on exposes it. A wrong trip run count is seen on oc_trip one sample earlier or later than the consecutive-sample rule allows.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int NSEG = 6;
  localparam int SEGW = 3;
  localparam logic [SEGW-1:0] SEG_STEADY = SEGW'(NSEG);

  typedef enum logic [1:0] {
    SS_LO2 = 2'b00,
    SS_LO3 = 2'b01,
    SS_LO4 = 2'b10,
    SS_LO1 = 2'b11
  } ss_sel_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ocp_seg_timer.sv
module ocp_seg_timer
  import ocp_pkg::*;
#(
  parameter int unsigned DUR0 = 6300,
  parameter int unsigned DUR1 = 2320,
  parameter int unsigned DUR2 = 3000,
  parameter int unsigned DUR3 = 4120,
  parameter int unsigned DUR4 = 6560,
  parameter int unsigned DUR5 = 14000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on_cmd,
  input  logic            fixed_mode,
  input  logic [1:0]      inrush_sel,
  input  logic [SEGW-1:0] start_seg,
  output logic            active,
  output logic [SEGW-1:0] seg
);
  localparam int unsigned BASE [NSEG] = '{DUR0, DUR1, DUR2, DUR3, DUR4, DUR5};
  localparam int unsigned MAXD = max_u(max_u(max_u(DUR0, DUR1), max_u(DUR2, DUR3)),
                                       max_u(DUR4, DUR5));
  localparam int TW = $clog2(MAXD * 8 + 1);

  logic [TW-1:0]   tcnt, tcnt_n, dur_sel;
  logic [SEGW-1:0] seg_n;
  logic            active_n;

  // length of the segment now running; inrush segments are scaled
  always_comb begin
    dur_sel = '0;
    for (int k = 0; k < NSEG; k++) begin
      if (seg == SEGW'(k)) begin
        if (k < 2) dur_sel = TW'(BASE[k]) << inrush_sel;
        else       dur_sel = TW'(BASE[k]);
      end
    end
  end

  always_comb begin
    active_n = on_cmd;
    seg_n    = seg;
    tcnt_n   = tcnt;
    if (on_cmd && !active) begin
      seg_n  = fixed_mode ? SEG_STEADY : start_seg;
      tcnt_n = '0;
    end else if (on_cmd && active && (seg != SEG_STEADY)) begin
      if (tcnt == dur_sel - TW'(1)) begin
        seg_n  = seg + SEGW'(1);
        tcnt_n = '0;
      end else begin
        tcnt_n = tcnt + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      seg    <= '0;
      tcnt   <= '0;
    end else begin
      active <= active_n;
      seg    <= seg_n;
      tcnt   <= tcnt_n;
    end
  end

  // R3: while running, the segment only holds or moves one step forward
  p_seg_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && on_cmd) |=> ((seg == $past(seg)) || (seg == $past(seg) + SEGW'(1))));
  // R3: never beyond steady state
  p_seg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg <= SEG_STEADY);
endmodule

// File: rtl/ocp_cool_tracker.sv
module ocp_cool_tracker
  import ocp_pkg::*;
#(
  parameter int unsigned COOL_BASE = 50000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [SEGW-1:0] seg,
  input  logic [1:0]      cool_sel,
  output logic [SEGW-1:0] warmth
);
  localparam int PW = $clog2(COOL_BASE * 8 + 1);

  logic [PW-1:0]   pcnt, pcnt_n, unit;
  logic [SEGW-1:0] warm_n;

  assign unit = PW'(COOL_BASE) << cool_sel;

  always_comb begin
    warm_n = warmth;
    pcnt_n = pcnt;
    if (active) begin
      warm_n = seg;
      pcnt_n = '0;
    end else if (pcnt == unit - PW'(1)) begin
      pcnt_n = '0;
      if (warmth != '0) warm_n = warmth - SEGW'(1);
    end else begin
      pcnt_n = pcnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warmth <= '0;
      pcnt   <= '0;
    end else begin
      warmth <= warm_n;
      pcnt   <= pcnt_n;
    end
  end

  // R8: an idle channel only cools, it never warms up
  p_cool_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (warmth <= $past(warmth)));
endmodule

// File: rtl/ocp_level_map.sv
module ocp_level_map
  import ocp_pkg::*;
#(
  parameter int CW = 8,
  parameter int unsigned LVL_H1  = 250,
  parameter int unsigned LVL_H2  = 200,
  parameter int unsigned LVL_C1  = 160,
  parameter int unsigned LVL_C2  = 130,
  parameter int unsigned LVL_C3  = 110,
  parameter int unsigned LVL_C4  = 95,
  parameter int unsigned LVL_LO1 = 80,
  parameter int unsigned LVL_LO2 = 60,
  parameter int unsigned LVL_LO3 = 45,
  parameter int unsigned LVL_LO4 = 30
) (
  input  logic            active,
  input  logic [SEGW-1:0] seg,
  input  logic            xen_shape,
  input  logic            hi_inrush,
  input  logic [1:0]      ss_sel,
  output logic [CW-1:0]   thr
);
  logic [CW-1:0] steady, lvl;

  always_comb begin
    case (ss_sel_e'(ss_sel))
      SS_LO3:  steady = CW'(LVL_LO3);
      SS_LO4:  steady = CW'(LVL_LO4);
      SS_LO1:  steady = CW'(LVL_LO1);
      default: steady = CW'(LVL_LO2);
    endcase
  end

  always_comb begin
    case (seg)
      3'd0:    lvl = CW'(LVL_H1);
      3'd1:    lvl = hi_inrush ? CW'(LVL_H1) : CW'(LVL_H2);
      3'd2:    lvl = CW'(LVL_C1);
      3'd3:    lvl = CW'(LVL_C2);
      3'd4:    lvl = xen_shape ? CW'(LVL_C3) : CW'(LVL_C2);
      3'd5:    lvl = xen_shape ? CW'(LVL_C4) : CW'(LVL_C2);
      default: lvl = steady;
    endcase
    thr = active ? lvl : '0;
  end
endmodule

// File: rtl/ocp_trip_filter.sv
module ocp_trip_filter #(
  parameter int CW       = 8,
  parameter int TRIP_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_cmd,
  input  logic          active,
  input  logic          sample_valid,
  input  logic [CW-1:0] cur_code,
  input  logic [CW-1:0] thr,
  output logic          trip
);
  localparam int RW = $clog2(TRIP_RUN + 1);

  logic [RW-1:0] run, run_n;
  logic          trip_n;

  always_comb begin
    run_n  = run;
    trip_n = trip;
    if (!on_cmd || !active) begin
      run_n  = '0;
      trip_n = 1'b0;
    end else if (sample_valid) begin
      if (cur_code > thr) begin
        if (run == RW'(TRIP_RUN - 1)) trip_n = 1'b1;
        else                          run_n  = run + RW'(1);
      end else begin
        run_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      trip <= 1'b0;
    end else begin
      run  <= run_n;
      trip <= trip_n;
    end
  end

  // R11: held while commanded on, dropped once the command goes low
  p_trip_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && on_cmd && active) |=> trip);
  p_trip_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !on_cmd |=> !trip);
endmodule

// File: rtl/ocp_inrush_seq.sv
module ocp_inrush_seq
  import ocp_pkg::*;
#(
  parameter int CUR_W = 8,
  parameter int unsigned DUR0 = 6300,
  parameter int unsigned DUR1 = 2320,
  parameter int unsigned DUR2 = 3000,
  parameter int unsigned DUR3 = 4120,
  parameter int unsigned DUR4 = 6560,
  parameter int unsigned DUR5 = 14000,
  parameter int unsigned COOL_BASE = 50000,
  parameter int TRIP_RUN = 4,
  parameter int unsigned LVL_H1  = 250,
  parameter int unsigned LVL_H2  = 200,
  parameter int unsigned LVL_C1  = 160,
  parameter int unsigned LVL_C2  = 130,
  parameter int unsigned LVL_C3  = 110,
  parameter int unsigned LVL_C4  = 95,
  parameter int unsigned LVL_LO1 = 80,
  parameter int unsigned LVL_LO2 = 60,
  parameter int unsigned LVL_LO3 = 45,
  parameter int unsigned LVL_LO4 = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_cmd,
  input  logic             sample_valid,
  input  logic [CUR_W-1:0] cur_code,
  input  logic             xen_shape,
  input  logic             hi_inrush,
  input  logic [1:0]       ss_sel,
  input  logic [1:0]       cool_sel,
  input  logic [1:0]       inrush_sel,
  input  logic             fixed_mode,
  output logic [CUR_W-1:0] thr_code,
  output logic [2:0]       prof_seg,
  output logic             oc_trip
);
  logic [1:0]      rst_pipe;
  logic            rst_int;
  logic            active;
  logic [SEGW-1:0] seg, warmth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  ocp_seg_timer #(
    .DUR0(DUR0), .DUR1(DUR1), .DUR2(DUR2), .DUR3(DUR3), .DUR4(DUR4), .DUR5(DUR5)
  ) u_timer (
    .clk(clk), .rst_n(rst_int), .on_cmd(on_cmd), .fixed_mode(fixed_mode),
    .inrush_sel(inrush_sel), .start_seg(warmth), .active(active), .seg(seg)
  );

  ocp_cool_tracker #(.COOL_BASE(COOL_BASE)) u_cool (
    .clk(clk), .rst_n(rst_int), .active(active), .seg(seg),
    .cool_sel(cool_sel), .warmth(warmth)
  );

  ocp_level_map #(
    .CW(CUR_W), .LVL_H1(LVL_H1), .LVL_H2(LVL_H2), .LVL_C1(LVL_C1), .LVL_C2(LVL_C2),
    .LVL_C3(LVL_C3), .LVL_C4(LVL_C4), .LVL_LO1(LVL_LO1), .LVL_LO2(LVL_LO2),
    .LVL_LO3(LVL_LO3), .LVL_LO4(LVL_LO4)
  ) u_map (
    .active(active), .seg(seg), .xen_shape(xen_shape), .hi_inrush(hi_inrush),
    .ss_sel(ss_sel), .thr(thr_code)
  );

  ocp_trip_filter #(.CW(CUR_W), .TRIP_RUN(TRIP_RUN)) u_trip (
    .clk(clk), .rst_n(rst_int), .on_cmd(on_cmd), .active(active),
    .sample_valid(sample_valid), .cur_code(cur_code), .thr(thr_code), .trip(oc_trip)
  );

  assign prof_seg = seg;

  // R2: a low command yields a zero limit on the next cycle
  p_thr_off_r2: assert property (@(posedge clk) disable iff (!rst_int)
    !on_cmd |=> (thr_code == '0));
  // R9: fixed mode switches on directly into steady state
  p_fixed_start_r9: assert property (@(posedge clk) disable iff (!rst_int)
    (on_cmd && !active && fixed_mode) |=> (prof_seg == SEG_STEADY));
endmodule

// File: tb/ocp_inrush_seq_bench.sv
module ocp_inrush_seq_bench;
  localparam int D [6] = '{20, 10, 12, 14, 16, 18};
  localparam int CB = 8;
  localparam int RUN = 3;

  typedef struct {
    int         cyc;
    logic [7:0] thr;
    logic [2:0] seg;
    bit         chk_seg;
    logic       trip;
    string      req;
  } item_t;

  logic clk = 0, rst_n = 0, on_cmd = 0, sample_valid = 0;
  logic [7:0] cur_code = 0;
  logic xen_shape = 1, hi_inrush = 0, fixed_mode = 0;
  logic [1:0] ss_sel = 0, cool_sel = 0, inrush_sel = 0;
  logic [7:0] thr_code;
  logic [2:0] prof_seg;
  logic       oc_trip;

  int cyc = 0, checks = 0, fails = 0;
  int last_seg = 0;
  bit done = 0;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ocp_inrush_seq #(
    .DUR0(D[0]), .DUR1(D[1]), .DUR2(D[2]), .DUR3(D[3]), .DUR4(D[4]), .DUR5(D[5]),
    .COOL_BASE(CB), .TRIP_RUN(RUN)
  ) u_ocp_inrush_seq (
    .clk(clk), .rst_n(rst_n), .on_cmd(on_cmd), .sample_valid(sample_valid),
    .cur_code(cur_code), .xen_shape(xen_shape), .hi_inrush(hi_inrush),
    .ss_sel(ss_sel), .cool_sel(cool_sel), .inrush_sel(inrush_sel),
    .fixed_mode(fixed_mode), .thr_code(thr_code), .prof_seg(prof_seg), .oc_trip(oc_trip)
  );

  function automatic int bdur(int k);
    return (k < 2) ? (D[k] << inrush_sel) : D[k];
  endfunction

  function automatic int seg_at(int s, int o);
    int t = o - 1;
    while (s < 6 && t >= bdur(s)) begin
      t = t - bdur(s);
      s = s + 1;
    end
    return s;
  endfunction

  function automatic logic [7:0] blevel(int s);
    case (s)
      0: return 250;
      1: return hi_inrush ? 8'd250 : 8'd200;
      2: return 160;
      3: return 130;
      4: return xen_shape ? 8'd110 : 8'd130;
      5: return xen_shape ? 8'd95 : 8'd130;
      default: case (ss_sel)
        2'b01: return 45;
        2'b10: return 30;
        2'b11: return 80;
        default: return 60;
      endcase
    endcase
  endfunction

  task automatic push(int k, logic [7:0] thr, int seg, bit cs, logic trip, string req);
    item_t it;
    it.cyc = cyc + k; it.thr = thr; it.seg = 3'(seg); it.chk_seg = cs;
    it.trip = trip; it.req = req;
    q.push_back(it);
  endtask

  task automatic run_on(int start, int n, string req);
    on_cmd = 1;
    for (int o = 1; o <= n; o++) push(o, blevel(seg_at(start, o)), seg_at(start, o), 1, 0, req);
    last_seg = seg_at(start, n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_off(int n, string req);
    on_cmd = 0;
    for (int o = 1; o <= n; o++) push(o, 8'd0, 0, 0, 0, req);
    repeat (n) @(negedge clk);
  endtask

  function automatic int warm_after(int l);
    int w = last_seg - l / (CB << cool_sel);
    return (w < 0) ? 0 : w;
  endfunction

  // monitor: compare outputs mid-high phase
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #2;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        it = q.pop_front();
        checks++;
        if (thr_code !== it.thr || oc_trip !== it.trip || (it.chk_seg && prof_seg !== it.seg)) begin
          fails++;
          $display("FAIL %s cyc=%0d thr=%0d/%0d seg=%0d/%0d trip=%0b/%0b (actual/expected)",
                   it.req, cyc, thr_code, it.thr, prof_seg, it.seg, oc_trip, it.trip);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int tc;
    int w;
    @(negedge clk);
    push(1, 8'd0, 0, 1, 0, "R1 reset state");
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 R2 R3 R4 R5: cold start walks the full xenon staircase into LO2
    run_on(0, 100, "R1 R2 R3 R4 R5 cold profile");
    run_off(5, "R2 off zero");
    w = warm_after(5);
    run_on(w, 5, "R8 short off keeps steady");
    // R10 R11: trip filter at steady LO2 = 60
    tc = 0;
    begin
      logic [7:0] vals [8] = '{61, 61, 60, 99, 61, 61, 61, 0};
      bit         vld  [8] = '{1, 1, 1, 0, 1, 1, 1, 1};
      bit         tr = 0;
      for (int i = 0; i < 8; i++) begin
        sample_valid = vld[i]; cur_code = vals[i];
        if (vld[i] && vals[i] > 60) begin tc++; if (tc >= RUN) tr = 1; end
        else if (vld[i]) tc = 0;
        push(1, 8'd60, 6, 1, tr, "R10 R11 trip run");
        @(negedge clk);
      end
    end
    sample_valid = 1; cur_code = 255;
    run_off(6, "R10 R11 ignored while off, trip cleared");
    sample_valid = 0; cur_code = 0;
    // R5: other steady-state selections
    for (int s = 1; s < 4; s++) begin
      ss_sel = 2'(s);
      w = warm_after(3);
      run_on(w, 3, "R5 steady select");
      run_off(3, "R2 off zero");
    end
    ss_sel = 0;
    // R8: cooling by whole units
    w = warm_after(3);
    run_on(w, 2, "R8 restart");
    run_off(20, "R8 cool off");
    w = warm_after(20);
    run_on(w, 40, "R8 restart after two units");
    cool_sel = 1;
    run_off(40, "R8 cool off scaled");
    w = warm_after(40);
    run_on(w, 10, "R8 restart scaled unit");
    run_off(3, "R8 brief off mid profile");
    w = warm_after(3);
    run_on(w, 4, "R8 resume mid profile");
    cool_sel = 0;
    run_off(200, "R8 full cool");
    // R3 R6 R7: non-xenon shape, high inrush, scaled inrush lengths
    xen_shape = 0; hi_inrush = 1; inrush_sel = 1;
    w = warm_after(200);
    run_on(w, 125, "R3 R6 R7 shaped profile");
    run_off(200, "R2 off zero");
    xen_shape = 1; hi_inrush = 0; inrush_sel = 0;
    // R9: fixed mode from a cold channel
    fixed_mode = 1;
    run_on(6, 6, "R9 fixed mode steady");
    run_off(3, "R2 off zero");
    fixed_mode = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule